// File: doc/BRIEF.md
# Two-Part Translation Lookup Engine

This block translates nothing by itself; it finds which translation entry covers a virtual address. Entries live in two stores. The banked store is set-associative, and all of its entries use one page size that the caller supplies with each lookup. The loose store is small and fully associative, and each of its entries records its own page size. Every entry maps an aligned pair of neighbouring pages. Its tag is therefore kept as virtual address bits 47:13, and it is compared after alignment to the page size in force.

A caller raises `start` for one cycle with the address, the current address-space ID and the banked page size. Two cycles later `done` pulses, together with the hit flag and the flat index of the winning entry. A new lookup may start every cycle. A plain write port fills entries by flat index. Banked entries come first in that index space, and loose entries follow them.

Top module: `lkup_engine`

## Requirements
- R1: After reset every entry is empty; `done`, `hit` and `hit_idx` are 0, and any lookup misses.
- R2: A `start` sampled in cycle c produces a `done` pulse of exactly one cycle in cycle c+2; starts in consecutive cycles each produce their own result, in order.
- R3: An entry matches only when its exist bit is 1 and its stored tag (virtual address bits 47:13), shifted right by ps-12, equals the address shifted right by ps+1, where ps is the page-size exponent; both pages of the pair therefore hit the same entry.
- R4: In the banked store the set is the low log2(SETS) bits of the address shifted right by gps+1, and the flat index is way*SETS+set; an entry held in another set never matches.
- R5: An entry whose global bit is 1 matches under any address-space ID; otherwise its stored ID must equal `asid`.
- R6: A loose-store entry uses its own stored page size for both shifts and reports flat index WAYS*SETS+slot.
- R7: Any banked match wins over every loose match; among banked matches the lowest way wins, and among loose matches the lowest slot wins.
- R8: When nothing matches, `done` still pulses with `hit`=0 and `hit_idx`=0.
- R9: A write taken in the same cycle as `start` is seen by that lookup; a write taken in the cycle after `start` is not. Indices below WAYS*SETS write the banked store and ignore `wr_ps`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a lookup this cycle |
| va | input | 48 | Virtual address to look up |
| asid | input | 10 | Current address-space ID |
| gps | input | 6 | Page-size exponent for the banked store (12 or more) |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Flat index of the entry written |
| wr_exist | input | 1 | Exist bit to store |
| wr_glob | input | 1 | Global bit to store |
| wr_asid | input | 10 | Address-space ID to store |
| wr_vppn | input | 35 | Tag to store: virtual address bits 47:13 |
| wr_ps | input | 6 | Page-size exponent, used by the loose store only |
| done | output | 1 | Result valid pulse |
| hit | output | 1 | An entry matched |
| hit_idx | output | 6 | Flat index of the winning entry, 0 on a miss |

## Verification
Every result is due in the second cycle after its `start`: the request is registered at the first edge, and the compare result is registered at the second. The bench drives inputs on the falling edge. Its reference model evaluates a pending request at each rising edge against the entry contents from before that edge's write, and it compares `done`, `hit` and `hit_idx` on every falling edge. The directed lookups check each outcome exactly two falling edges after they raise `start`. The write-timing tests place a write in the start cycle and in the cycle after it, to pin down which contents a lookup sees.

// File: rtl/lkup_pkg.sv
package lkup_pkg;
  parameter int unsigned VA_W    = 48;
  parameter int unsigned ASID_W  = 10;
  parameter int unsigned PS_W    = 6;
  parameter int unsigned TAG_LSB = 13;
  parameter int unsigned TAG_W   = VA_W - TAG_LSB;

  typedef struct packed {
    logic              exist;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [TAG_W-1:0]  vppn;
    logic [PS_W-1:0]   ps;
  } tlb_ent_t;

  // page-pair number of an address: one entry covers two pages
  function automatic logic [VA_W-1:0] pair_page(input logic [VA_W-1:0] a,
                                                input logic [PS_W-1:0] ps);
    return a >> (int'(ps) + 1);
  endfunction

  // stored tag starts at bit TAG_LSB; align it to the pair number
  function automatic logic [VA_W-1:0] tag_align(input logic [TAG_W-1:0] t,
                                                input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] wide;
    wide = {{TAG_LSB{1'b0}}, t};
    return wide >> (int'(ps) + 1 - int'(TAG_LSB));
  endfunction

  function automatic logic ent_match(input tlb_ent_t e,
                                     input logic [VA_W-1:0] a,
                                     input logic [ASID_W-1:0] id,
                                     input logic [PS_W-1:0] ps);
    return e.exist && (e.glob || (e.asid == id)) &&
           (tag_align(e.vppn, ps) == pair_page(a, ps));
  endfunction
endpackage

// File: rtl/lkup_pick.sv
module lkup_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end

  // R7: the chosen requester is set and no lower requester is set
  always_comb begin
    if (any) begin
      assert_pick_valid_R7: assert (req[idx]) else $error("pick chose idle input");
      for (int i = 0; i < N; i++) begin
        if (i < int'(idx)) begin
          assert_pick_lowest_R7: assert (!req[i]) else $error("pick skipped lower input");
        end
      end
    end
  end
endmodule

// File: rtl/lkup_sa_bank.sv
module lkup_sa_bank
  import lkup_pkg::*;
#(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned SA_N  = WAYS * SETS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [VA_W-1:0]   look_va,
  input  logic [ASID_W-1:0] look_asid,
  input  logic [PS_W-1:0]   look_ps,
  output logic [WAYS-1:0]   way_hit,
  output logic [SET_W-1:0]  set_sel
);
  tlb_ent_t mem [SA_N];
  logic [VA_W-1:0] pnum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SA_N); i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < int'(SA_N))) begin
      mem[int'(wr_idx)] <= wr_ent;
    end
  end

  always_comb begin
    pnum    = pair_page(look_va, look_ps);
    set_sel = pnum[SET_W-1:0];
  end

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    assign way_hit[w] = ent_match(mem[w * int'(SETS) + int'(set_sel)],
                                  look_va, look_asid, look_ps);
  end
endmodule

// File: rtl/lkup_fa_bank.sv
module lkup_fa_bank
  import lkup_pkg::*;
#(
  parameter int unsigned FA_N  = 8,
  parameter int unsigned BASE  = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [VA_W-1:0]   look_va,
  input  logic [ASID_W-1:0] look_asid,
  output logic [FA_N-1:0]   slot_hit
);
  tlb_ent_t mem [FA_N];
  logic     in_range;

  assign in_range = (int'(wr_idx) >= int'(BASE)) &&
                    (int'(wr_idx) < int'(BASE + FA_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(FA_N); i++) mem[i] <= '0;
    end else if (wr_en && in_range) begin
      mem[int'(wr_idx) - int'(BASE)] <= wr_ent;
    end
  end

  for (genvar s = 0; s < int'(FA_N); s++) begin : g_slot
    assign slot_hit[s] = ent_match(mem[s], look_va, look_asid, mem[s].ps);
  end
endmodule

// File: rtl/lkup_engine.sv
module lkup_engine
  import lkup_pkg::*;
#(
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 16,
  parameter int unsigned FA_N = 8,
  localparam int unsigned SA_N  = WAYS * SETS,
  localparam int unsigned IDX_W = $clog2(SA_N + FA_N),
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SLT_W = (FA_N > 1) ? $clog2(FA_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [47:0]       va,
  input  logic [9:0]        asid,
  input  logic [5:0]        gps,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_exist,
  input  logic              wr_glob,
  input  logic [9:0]        wr_asid,
  input  logic [34:0]       wr_vppn,
  input  logic [5:0]        wr_ps,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  // stage 1: registered request
  logic              s1_v;
  logic [VA_W-1:0]   s1_va;
  logic [ASID_W-1:0] s1_asid;
  logic [PS_W-1:0]   s1_ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_va   <= '0;
      s1_asid <= '0;
      s1_ps   <= '0;
    end else begin
      s1_v <= start;
      if (start) begin
        s1_va   <= va;
        s1_asid <= asid;
        s1_ps   <= gps;
      end
    end
  end

  tlb_ent_t wr_ent;
  assign wr_ent = '{exist: wr_exist, glob: wr_glob, asid: wr_asid,
                    vppn: wr_vppn, ps: wr_ps};

  logic [WAYS-1:0]  way_hit;
  logic [SET_W-1:0] set_sel;
  logic [FA_N-1:0]  slot_hit;
  logic             sa_any, fa_any;
  logic [WAY_W-1:0] way_win;
  logic [SLT_W-1:0] slot_win;

  lkup_sa_bank #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W)) sa_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .look_va(s1_va), .look_asid(s1_asid), .look_ps(s1_ps),
    .way_hit(way_hit), .set_sel(set_sel)
  );

  lkup_fa_bank #(.FA_N(FA_N), .BASE(SA_N), .IDX_W(IDX_W)) fa_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .look_va(s1_va), .look_asid(s1_asid), .slot_hit(slot_hit)
  );

  lkup_pick #(.N(WAYS)) sa_pick_i (.req(way_hit),  .any(sa_any), .idx(way_win));
  lkup_pick #(.N(FA_N)) fa_pick_i (.req(slot_hit), .any(fa_any), .idx(slot_win));

  // banked result first, loose store only when the banks miss
  logic [IDX_W-1:0] res_idx;
  always_comb begin
    if (sa_any)      res_idx = IDX_W'(int'(way_win) * int'(SETS) + int'(set_sel));
    else if (fa_any) res_idx = IDX_W'(int'(SA_N) + int'(slot_win));
    else             res_idx = '0;
  end

  // stage 2: registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      done    <= s1_v;
      hit     <= s1_v && (sa_any || fa_any);
      hit_idx <= s1_v ? res_idx : '0;
    end
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s1_v);
  assert_done_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> done);
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s1_v));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));
  assert_hit_has_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done);
  assert_banks_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && sa_any) |=> (hit && (int'(hit_idx) < int'(SA_N))));
  assert_loose_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !sa_any && fa_any) |=> (hit && (int'(hit_idx) >= int'(SA_N))));
endmodule

// File: tb/lkup_engine_tb.sv
module lkup_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int WAYS = 2, SETS = 16, FA_N = 8;
  localparam int SA_N = WAYS * SETS, NTOT = SA_N + FA_N, IDX_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [47:0] va = '0;
  logic [9:0] asid = '0;
  logic [5:0] gps = 6'd12;
  logic wr_en = 1'b0, wr_exist = 1'b0, wr_glob = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [9:0] wr_asid = '0;
  logic [34:0] wr_vppn = '0;
  logic [5:0] wr_ps = '0;
  logic done, hit;
  logic [IDX_W-1:0] hit_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  lkup_engine #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .asid(asid), .gps(gps),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_exist(wr_exist), .wr_glob(wr_glob),
    .wr_asid(wr_asid), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
    .done(done), .hit(hit), .hit_idx(hit_idx));

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_exist[NTOT], m_glob[NTOT];
  int m_asid[NTOT], m_ps[NTOT];
  longint unsigned m_vppn[NTOT];
  bit p_v = 0; longint unsigned p_va; int p_asid, p_gps;
  bit e_done = 0, e_hit = 0; int e_idx = 0;

  function automatic bit m_match(int e, longint unsigned a, int id, int ps);
    longint unsigned full;
    full = m_vppn[e] << 13;
    return m_exist[e] && (m_glob[e] || m_asid[e] == id) &&
           ((full >> (ps + 1)) == (a >> (ps + 1)));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTOT; i++) m_exist[i] = 0;
      p_v = 0; e_done = 0; e_hit = 0; e_idx = 0;
    end else begin
      e_done = p_v; e_hit = 0; e_idx = 0;
      if (p_v) begin
        int set;
        set = int'((p_va >> (p_gps + 1)) % SETS);
        for (int w = 0; w < WAYS && !e_hit; w++)
          if (m_match(w * SETS + set, p_va, p_asid, p_gps)) begin e_hit = 1; e_idx = w * SETS + set; end
        for (int s = 0; s < FA_N && !e_hit; s++)
          if (m_match(SA_N + s, p_va, p_asid, m_ps[SA_N + s])) begin e_hit = 1; e_idx = SA_N + s; end
      end
      if (wr_en && wr_idx < NTOT) begin
        m_exist[wr_idx] = wr_exist; m_glob[wr_idx] = wr_glob; m_asid[wr_idx] = wr_asid;
        m_vppn[wr_idx] = wr_vppn; m_ps[wr_idx] = wr_ps;
      end
      p_v = start; p_va = va; p_asid = asid; p_gps = gps;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 model done", done, e_done);
      chk("R2 model hit", hit, e_hit);
      chk("R2 model idx", hit_idx, e_idx);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input int idx, input bit ex, input bit gl, input int id,
                    input longint unsigned tag, input int ps);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_exist = ex; wr_glob = gl;
    wr_asid = 10'(id); wr_vppn = 35'(tag); wr_ps = 6'(ps);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input longint unsigned a, input int id, input int ps,
                      input bit xh, input int xi, input string req);
    @(negedge clk);
    start = 1; va = 48'(a); asid = 10'(id); gps = 6'(ps);
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk({req, " done"}, done, 1);
    chk({req, " hit"}, hit, xh);
    chk({req, " idx"}, hit_idx, xi);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset hit", hit, 0);
    chk("R1 reset idx", hit_idx, 0);
    rst_n = 1;
    look(48'h2468BABC, 0, 12, 0, 0, "R1 empty miss");

    // banked: tag 0x12345 lives in set 5 at 4 KiB pages
    wr(5, 1, 0, 3, 35'h12345, 0);
    look(48'h2468BABC, 3, 12, 1, 5, "R3 odd page");
    look(48'h2468A000, 3, 12, 1, 5, "R3 even page");
    look(48'h2468C000, 3, 12, 0, 0, "R8 next pair miss");
    look(48'h2468BABC, 4, 12, 0, 0, "R5 asid mismatch");
    wr(21, 1, 1, 7, 35'h12345, 0);
    look(48'h2468BABC, 4, 12, 1, 21, "R5 global way1");
    look(48'h2468BABC, 3, 12, 1, 5, "R7 lowest way");

    // banked at 16 KiB pages: pair number 0x2469, set 9
    wr(9, 1, 0, 1, 35'h91A4, 0);
    look(48'h1234FFFF, 1, 14, 1, 9, "R4 set from gps14");
    look(48'h12348000, 1, 12, 0, 0, "R4 other set");

    // loose store with its own page sizes
    wr(SA_N + 2, 1, 1, 0, 35'h3FA00, 21);
    look(48'h7F7FFFFF, 0, 12, 1, SA_N + 2, "R6 own size");
    look(48'h7F800000, 0, 12, 0, 0, "R8 beyond pair");
    wr(SA_N + 5, 1, 1, 0, 35'h3FA00, 22);
    look(48'h7F400000, 9, 14, 1, SA_N + 2, "R7 lowest slot");
    look(48'h7F100000, 9, 14, 1, SA_N + 5, "R6 larger page");
    wr(0, 1, 1, 0, 35'h3FA00, 0);
    look(48'h7F400000, 9, 12, 1, 0, "R7 banked over loose");
    wr(0, 0, 1, 0, 35'h3FA00, 0);
    look(48'h7F400000, 9, 12, 1, SA_N + 2, "R3 exist cleared");

    // R9: write in start cycle is seen
    @(negedge clk);
    wr_en = 1; wr_idx = 6; wr_exist = 1; wr_glob = 0; wr_asid = 2; wr_vppn = 35'h6; wr_ps = 0;
    start = 1; va = 48'h0000C123; asid = 2; gps = 12;
    @(negedge clk);
    wr_en = 0; start = 0;
    @(negedge clk);
    chk("R9 same-cycle write hit", hit, 1);
    chk("R9 same-cycle write idx", hit_idx, 6);
    // R9: write one cycle after start is not seen
    start = 1; va = 48'h0000E000; asid = 2; gps = 12;
    @(negedge clk);
    start = 0;
    wr_en = 1; wr_idx = 7; wr_exist = 1; wr_glob = 0; wr_asid = 2; wr_vppn = 35'h7; wr_ps = 0;
    @(negedge clk);
    wr_en = 0;
    chk("R9 late write unseen", hit, 0);
    look(48'h0000E000, 2, 12, 1, 7, "R9 later lookup");

    // back-to-back and mixed traffic, checked by the model
    for (int n = 0; n < 400; n++) begin
      longint unsigned bases[6];
      bases = '{48'h2468A000, 48'h12348000, 48'h7F400000, 48'h0000C000, 48'h0000E000, 48'h7F000000};
      @(negedge clk);
      start = ($urandom % 4) != 0;
      va = 48'(bases[$urandom % 6] + ($urandom % 32'h40000));
      asid = 10'($urandom % 8);
      gps = ($urandom % 2) ? 6'd12 : 6'd14;
      wr_en = ($urandom % 8) == 0;
      wr_idx = IDX_W'($urandom % NTOT);
      wr_exist = $urandom % 2; wr_glob = $urandom % 2; wr_asid = 10'($urandom % 8);
      wr_vppn = 35'((bases[$urandom % 6] >> 13) + ($urandom % 8));
      wr_ps = 6'(12 + $urandom % 12);
    end
    @(negedge clk);
    start = 0; wr_en = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule